// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start Validation

This block turns an asynchronous serial line into bytes for a host. A receive-rate enable, `rx_clk_en`, pulses once per receive-clock period and sets the bit rate independently of the host clock `clk`. It runs at 1, 16 or 64 receive-clock periods per bit, chosen by `rate_sel`. The serial input first passes through a synchronizer. Any high-to-low transition seen on a rate tick is treated as a candidate start bit. The line is then checked again half a bit later. A candidate that has gone high again by that point is dropped as a glitch.

Once a start bit is validated, the data bits are sampled at the middle of each bit, least significant first, into a shift register. The stop position is sampled last. The finished byte then moves into a separate holding register, so the next frame can be assembled while the host still holds the previous byte. A ready flag tells the host that a byte is waiting. An overrun flag shows that an unread byte was replaced. A break output reports a frame that stayed low from the start bit through the stop position.

Top module: `asy_rx`

## Requirements
- R1: After reset, `rx_ready`, `overrun` and `brk` are 0 and `rx_data` is 0.
- R2: A rate tick that sees the synchronized line low, after the previous tick in idle saw it high, starts a frame. If the line is still low half a bit later (factor/2 ticks, or on the same tick when the factor is 1), the frame proceeds. Data bits are sampled every factor ticks after that, least significant bit first. When the stop position is sampled, the byte appears on `rx_data` and `rx_ready` goes to 1 on the next clock.
- R3: If the line is high at the half-bit check, the receiver goes back to idle. `rx_data`, `rx_ready` and `overrun` are left unchanged.
- R4: `rate_sel` sets the ticks per bit: 2'b00 gives 1, 2'b01 gives 16, and 2'b10 or 2'b11 give 64.
- R5: The holding register changes only when a frame completes. A byte that is held stays on `rx_data` while the next frame is being shifted in.
- R6: A one-cycle `rd_stb` with no frame completing in the same cycle clears `rx_ready` and `overrun` on the next clock.
- R7: If a frame completes while `rx_ready` is 1 and no read happens in that cycle, `overrun` becomes 1 and the new byte replaces the old one.
- R8: If every data bit and the stop position are sampled low, `brk` goes to 1 and no byte is loaded. `brk` returns to 0 once the synchronized line is high again, and no new frame can start until the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_clk_en | input | 1 | One pulse per receive-clock period |
| rate_sel | input | 2 | Ticks per bit: 00=1, 01=16, 10/11=64 |
| rxd | input | 1 | Serial input, idle high |
| rd_stb | input | 1 | Host read of the holding register |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | A byte is waiting in the holding register |
| overrun | output | 1 | An unread byte was replaced |
| brk | output | 1 | Break seen on the line |

## Verification
The bench uses the defaults: 8 data bits, a two-stage synchronizer and a largest rate factor of 64. With these, all four `rate_sel` codes can be reached, including the single-tick mode, where validation and sampling fall on consecutive ticks. Random bytes at random rates are mixed with directed cases: a start pulse shorter than half a bit, a second frame arriving while a byte is held, an unread byte being overwritten, and a line held low for a whole frame and then released.

// File: rtl/asy_rx_pkg.sv
package asy_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   // ticks per bit for each rate code
   function automatic int unsigned rate_factor(input logic [1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 16;
         default: return 64;
      endcase
   endfunction

endpackage

// File: rtl/asy_rx_sync.sv
module asy_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/asy_rx_rate.sv
module asy_rx_rate
   import asy_rx_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] step_m1,
   output logic [CNT_W-1:0] half_m1,
   output logic             half_zero
);
   int unsigned fac;
   int unsigned half;

   always_comb begin
      fac       = rate_factor(sel);
      half      = fac / 2;
      step_m1   = CNT_W'(fac - 1);
      half_zero = (half == 0);
      half_m1   = half_zero ? '0 : CNT_W'(half - 1);
   end
endmodule

// File: rtl/asy_rx_frame.sv
module asy_rx_frame
   import asy_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic [CNT_W-1:0]  step_m1,
   input  logic [CNT_W-1:0]  half_m1,
   input  logic              half_zero,
   output logic              done,
   output logic              brk_evt,
   output logic [DATA_W-1:0] shreg
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] bit_idx;
   logic             prev_hi;
   logic             all_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         prev_hi <= 1'b0;
         all_low <= 1'b0;
         shreg   <= '0;
         done    <= 1'b0;
         brk_evt <= 1'b0;
      end else begin
         done    <= 1'b0;
         brk_evt <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  prev_hi <= line;
                  if (prev_hi && !line) begin
                     if (half_zero) begin
                        state   <= ST_DATA;
                        cnt     <= step_m1;
                        bit_idx <= '0;
                        all_low <= 1'b1;
                     end else begin
                        state <= ST_START;
                        cnt   <= half_m1;
                     end
                  end
               end
               ST_START: begin
                  if (cnt != '0) begin
                     cnt <= cnt - 1'b1;
                  end else if (!line) begin
                     state   <= ST_DATA;
                     cnt     <= step_m1;
                     bit_idx <= '0;
                     all_low <= 1'b1;
                  end else begin
                     state   <= ST_IDLE;
                     prev_hi <= 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt != '0) begin
                     cnt <= cnt - 1'b1;
                  end else begin
                     shreg   <= {line, shreg[DATA_W-1:1]};
                     all_low <= all_low & ~line;
                     cnt     <= step_m1;
                     if (bit_idx == LAST_IDX) state <= ST_STOP;
                     else                     bit_idx <= bit_idx + 1'b1;
                  end
               end
               default: begin
                  if (cnt != '0) begin
                     cnt <= cnt - 1'b1;
                  end else begin
                     state   <= ST_IDLE;
                     prev_hi <= line;
                     if (all_low && !line) brk_evt <= 1'b1;
                     else                  done    <= 1'b1;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/asy_rx_hold.sv
module asy_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              brk_evt,
   input  logic              line,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] data,
   output logic              ready,
   output logic              ovr,
   output logic              brk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         ready <= 1'b0;
         ovr   <= 1'b0;
      end else if (load) begin
         data  <= load_data;
         ready <= 1'b1;
         ovr   <= ready & ~rd_stb;
      end else if (rd_stb) begin
         ready <= 1'b0;
         ovr   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       brk <= 1'b0;
      else if (brk_evt) brk <= 1'b1;
      else if (line)    brk <= 1'b0;
   end
endmodule

// File: rtl/asy_rx.sv
module asy_rx #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_FACTOR  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_clk_en,
   input  logic [1:0]        rate_sel,
   input  logic              rxd,
   input  logic              rd_stb,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              overrun,
   output logic              brk
);
   localparam int CNT_W = $clog2(MAX_FACTOR);

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("asy_rx: DATA_W must lie in 5..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("asy_rx: SYNC_STAGES must be at least 2");
   end
   if (MAX_FACTOR < 64 || (MAX_FACTOR & (MAX_FACTOR - 1)) != 0) begin : g_bad_fac
      $error("asy_rx: MAX_FACTOR must be a power of two of at least 64");
   end

   logic              line_s;
   logic [CNT_W-1:0]  step_m1;
   logic [CNT_W-1:0]  half_m1;
   logic              half_zero;
   logic              frame_done;
   logic              brk_evt;
   logic [DATA_W-1:0] shreg;

   asy_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (line_s)
   );

   asy_rx_rate #(.CNT_W(CNT_W)) u_rate (
      .sel       (rate_sel),
      .step_m1   (step_m1),
      .half_m1   (half_m1),
      .half_zero (half_zero)
   );

   asy_rx_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (rx_clk_en),
      .line      (line_s),
      .step_m1   (step_m1),
      .half_m1   (half_m1),
      .half_zero (half_zero),
      .done      (frame_done),
      .brk_evt   (brk_evt),
      .shreg     (shreg)
   );

   asy_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (frame_done),
      .load_data (shreg),
      .brk_evt   (brk_evt),
      .line      (line_s),
      .rd_stb    (rd_stb),
      .data      (rx_data),
      .ready     (rx_ready),
      .ovr       (overrun),
      .brk       (brk)
   );
endmodule

// File: rtl/asy_rx_chk.sv
module asy_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              rd_stb,
   input logic              line,
   input logic              load,
   input logic              brk_evt,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ready,
   input logic              overrun,
   input logic              brk
);
   AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rx_ready); // R2

   AST_LOAD_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> $past(tick)); // R2

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(rx_data)); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !load) |=> (!rx_ready && !overrun)); // R6

   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_ready)); // R7

   AST_BRK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> brk); // R8

   AST_BRK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && line && !brk_evt) |=> !brk); // R8

   AST_BRK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> $stable(rx_data)); // R8
endmodule

bind asy_rx asy_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (rx_clk_en),
   .rd_stb   (rd_stb),
   .line     (line_s),
   .load     (frame_done),
   .brk_evt  (brk_evt),
   .rx_data  (rx_data),
   .rx_ready (rx_ready),
   .overrun  (overrun),
   .brk      (brk)
);

// File: tb/asy_rx_bench.sv
module asy_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int N_RANDOM   = 14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_clk_en = 1'b0;
   logic [1:0] rate_sel = 2'b01;
   logic       rxd = 1'b1;
   logic       rd_stb = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready;
   logic       overrun;
   logic       brk;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_data = 8'h00;
   logic       exp_ready = 1'b0;
   logic       exp_ovr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   asy_rx u_asy_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_clk_en (rx_clk_en),
      .rate_sel  (rate_sel),
      .rxd       (rxd),
      .rd_stb    (rd_stb),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .overrun   (overrun),
      .brk       (brk)
   );

   function automatic int fac_of(input logic [1:0] sel);
      if (sel == 2'b00) return 1;
      if (sel == 2'b01) return 16;
      return 64;
   endfunction

   function automatic logic [9:0] mk_frame(input logic [7:0] b);
      return {1'b1, b, 1'b0};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(req, "rx_data", 32'(rx_data), 32'(exp_data));
      check(req, "rx_ready", 32'(rx_ready), 32'(exp_ready));
      check(req, "overrun", 32'(overrun), 32'(exp_ovr));
   endtask

   function automatic void model_load(input logic [7:0] b);
      exp_ovr   = exp_ready;
      exp_ready = 1'b1;
      exp_data  = b;
   endfunction

   function automatic void model_read();
      exp_ready = 1'b0;
      exp_ovr   = 1'b0;
   endfunction

   // each call starts and ends at a falling edge just after a tick
   task automatic step_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         repeat (TICK_DIV - 1) @(negedge clk);
         rx_clk_en = 1'b1;
         @(negedge clk);
         rx_clk_en = 1'b0;
      end
   endtask

   task automatic send_bits(input logic [9:0] fr, input int f,
                            input int lo, input int hi);
      for (int i = lo; i <= hi; i++) begin
         rxd = fr[i];
         step_ticks(f);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input int f);
      send_bits(mk_frame(b), f, 0, 9);
      rxd = 1'b1;
      step_ticks(f);
   endtask

   task automatic host_read();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      model_read();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] b;
      logic [1:0] sel;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check_all("R1");
      check("R1", "brk", 32'(brk), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      step_ticks(2);

      // R2: directed frame at 16 ticks per bit
      rate_sel = 2'b01;
      send_byte(8'hA5, 16);
      model_load(8'hA5);
      check_all("R2");
      host_read();
      check_all("R6");

      // R4: every rate code
      rate_sel = 2'b00;
      send_byte(8'h3C, 1);
      model_load(8'h3C);
      check_all("R4 x1");
      host_read();
      rate_sel = 2'b10;
      send_byte(8'h81, 64);
      model_load(8'h81);
      check_all("R4 x64");
      host_read();
      rate_sel = 2'b11;
      send_byte(8'h7E, 64);
      model_load(8'h7E);
      check_all("R4 code3");

      // R3: short start pulse while a byte is held
      rate_sel = 2'b01;
      rxd = 1'b0;
      step_ticks(4);
      rxd = 1'b1;
      step_ticks(40);
      check_all("R3");
      host_read();
      send_byte(8'h5A, 16);
      model_load(8'h5A);
      check_all("R3 recovery");

      // R5: held byte survives while the next frame shifts in
      send_bits(mk_frame(8'hC3), 16, 0, 5);
      check_all("R5 mid-frame");
      send_bits(mk_frame(8'hC3), 16, 6, 9);
      rxd = 1'b1;
      step_ticks(16);
      // R7: that frame landed on an unread byte
      model_load(8'hC3);
      check_all("R7");
      host_read();
      check_all("R6 clears overrun");

      // R8: line low for a whole frame
      rxd = 1'b0;
      step_ticks(16 * 10);
      check("R8", "brk set", 32'(brk), 32'd1);
      check_all("R8 no load");
      step_ticks(16 * 2);
      check_all("R8 no restart while low");
      rxd = 1'b1;
      step_ticks(2);
      check("R8", "brk cleared", 32'(brk), 32'd0);
      send_byte(8'h96, 16);
      model_load(8'h96);
      check_all("R8 recovery");
      host_read();

      // R2 random bytes at random rates
      for (int k = 0; k < N_RANDOM; k++) begin
         sel = 2'($urandom % 4);
         b   = 8'($urandom);
         rate_sel = sel;
         send_byte(b, fac_of(sel));
         model_load(b);
         check_all("R2 random");
         if (($urandom % 2) == 0) begin
            host_read();
            check_all("R6 random");
         end
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule